// File: doc/BRIEF.md
# Three-Level DMA Address Translator

This block turns a device DMA address into a physical page address for one of several device slots. A translate request carries the address and a slot number. The block reads that slot's table origin and address window from side-band vectors. It then walks three levels of tables in memory, one 64-bit read at a time: a region table, a segment table and a page table. Each request ends with one response pulse. The pulse carries the page address, a read/write permission and a 4 KiB page mask.

One address is reserved for interrupt messages. It skips the walk and maps to itself, with a flag that routes it to the interrupt target. Several conditions abort a translation: a missing table origin, an address outside the slot's window, or a failed walk. Each of these gives a no-permission response and an error event with its own code. It also sets a sticky per-slot error bit, which marks the slot as blocked for further stores.

Top module: `dma_xlate_walker`

## Requirements
- R1: For a walk, the region index is address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12]. Each read address is the table base plus the index times 8. The region base is the slot origin with bits [11:0] cleared. The segment base is the region entry with bits [13:0] cleared. The page base is the segment entry with bits [10:0] cleared.
- R2: A region entry is accepted only if bits [3:2] equal 2'b11. A segment entry is accepted only if bits [3:2] equal 2'b10. A mismatch ends the walk with no further read and raises a walk fault (code 3, qualifier set).
- R3: A request to a slot whose configured or occupied bit is low gets a response on the next cycle. That response has permission 2'b00, address 0 and an all-ones mask. It issues no memory read and raises no error event.
- R4: A request whose address equals MSI_ADDR, on a live slot, is checked before any other test. Its response has address equal to the request address, permission 2'b11, mask 0xFFF and rsp_msi high. It issues no read and raises no error.
- R5: On a live slot with a zero table origin, a non-interrupt request raises error code 1 with an error word of 0.
- R6: With a non-zero origin, an address below slot_lo or above slot_hi raises error code 2 with an error word of 0. The bounds themselves are accepted and walked.
- R7: A final page entry of zero raises error code 3 with error-word bit 0 (the qualifier) set.
- R8: A non-zero page entry gives address = entry with bits [11:0] cleared and mask 0xFFF. The permission is 2'b00 if entry bit 10 is set, otherwise 2'b11. No error is raised.
- R9: Every fault has the following effects:
  - err_valid pulses in the same cycle as a response with permission 2'b00, address 0 and an all-ones mask.
  - err_slot and err_addr name the request.
  - The slot's bit in slot_err is set and stays set until reset.
- R10: Only one translation is in flight. A request presented while busy is high is ignored. rsp_valid is high for exactly one cycle per accepted request.
- R11: After reset, busy, rsp_valid, err_valid, mem_rd_valid and slot_err are all zero.
- R12: mem_rd_valid stays high with a stable mem_rd_addr until a cycle with mem_rd_data_valid high, which consumes mem_rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request strobe |
| req_addr | input | AW | DMA address to translate |
| req_slot | input | SW | Requesting slot |
| busy | output | 1 | Walk in progress; requests ignored |
| slot_cfg | input | SLOTS | Per-slot configured flag |
| slot_used | input | SLOTS | Per-slot occupied flag |
| slot_org | input | SLOTS*AW | Per-slot table origin, slot i at bits [i*AW +: AW] |
| slot_lo | input | SLOTS*AW | Per-slot lowest legal address |
| slot_hi | input | SLOTS*AW | Per-slot highest legal address |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | AW | Byte address of the 8-byte entry |
| mem_rd_data_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | AW | Translated page address |
| rsp_perm | output | 2 | {read, write} permission |
| rsp_mask | output | AW | Page offset mask |
| rsp_msi | output | 1 | Route to interrupt target |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 2 | 1 no origin, 2 out of range, 3 walk fault |
| err_slot | output | SW | Slot of the faulting request |
| err_addr | output | AW | Faulting DMA address |
| err_word | output | 32 | Error detail; bit 0 is the walk qualifier |
| slot_err | output | SLOTS | Sticky per-slot error / store-block state |

## Verification
The bench builds the block with its default parameters: four slots, 64-bit addresses and 11/11/8-bit index fields. This reaches every slot and both extreme index values (2047 and 255). The memory model computes each entry from its own address. That lets the bench sweep a grid of region, segment and page indices and predict every read address, type mismatch, zero entry and invalid flag arithmetically. Read latency rotates over zero to two cycles, so the held-request behaviour is covered. Directed cases cover the slot gating, the interrupt bypass and its priority, both window bounds, and a request made while busy.

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int SLOTS    = 4,
  parameter int AW       = 64,
  parameter int PG_SHIFT = 12,
  parameter int PX_W     = 8,
  parameter int SX_W     = 11,
  parameter int RX_W     = 11,
  parameter int TYPE_LSB = 2,
  parameter int INV_BIT  = 10,
  parameter int Q_BIT    = 0,
  parameter logic [AW-1:0] MSI_ADDR = 'h0000_0000_FEE0_0000,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic [SW-1:0]      req_slot,
  output logic               busy,
  input  logic [SLOTS-1:0]   slot_cfg,
  input  logic [SLOTS-1:0]   slot_used,
  input  logic [SLOTS*AW-1:0] slot_org,
  input  logic [SLOTS*AW-1:0] slot_lo,
  input  logic [SLOTS*AW-1:0] slot_hi,
  output logic               mem_rd_valid,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rd_data_valid,
  input  logic [63:0]        mem_rd_data,
  output logic               rsp_valid,
  output logic [AW-1:0]      rsp_addr,
  output logic [1:0]         rsp_perm,
  output logic [AW-1:0]      rsp_mask,
  output logic               rsp_msi,
  output logic               err_valid,
  output logic [1:0]         err_code,
  output logic [SW-1:0]      err_slot,
  output logic [AW-1:0]      err_addr,
  output logic [31:0]        err_word,
  output logic [SLOTS-1:0]   slot_err
);
  localparam int SX_SH = PG_SHIFT + PX_W;
  localparam int RX_SH = SX_SH + SX_W;
  localparam logic [AW-1:0] PG_MASK = {{(AW-PG_SHIFT){1'b0}}, {PG_SHIFT{1'b1}}};
  localparam logic [AW-1:0] ST_ALN  = {{(AW-SX_W-3){1'b0}}, {(SX_W+3){1'b1}}};
  localparam logic [AW-1:0] PT_ALN  = {{(AW-PX_W-3){1'b0}}, {(PX_W+3){1'b1}}};
  localparam logic [1:0] RT_TYPE = 2'b11;
  localparam logic [1:0] ST_TYPE = 2'b10;

  typedef enum logic [1:0] {IDLE, RT, ST, PT} st_t;
  st_t st, nst;

  logic [AW-1:0] va, base, nbase, idx, org, lo, hi, cur_addr;
  logic [SW-1:0] slot, cur_slot;
  logic live, fin, flt, rmsi;
  logic [1:0] code, rperm;
  logic [AW-1:0] raddr, rmask;
  logic [AW-1:0] ent;
  logic [1:0] etype;

  assign org  = slot_org[req_slot*AW +: AW];
  assign lo   = slot_lo[req_slot*AW +: AW];
  assign hi   = slot_hi[req_slot*AW +: AW];
  assign live = (int'(req_slot) < SLOTS) && slot_cfg[req_slot] && slot_used[req_slot];

  assign busy         = (st != IDLE);
  assign mem_rd_valid = (st != IDLE);
  assign mem_rd_addr  = base + (idx << 3);
  assign ent          = AW'(mem_rd_data);
  assign etype        = mem_rd_data[TYPE_LSB +: 2];
  assign cur_addr     = (st == IDLE) ? req_addr : va;
  assign cur_slot     = (st == IDLE) ? req_slot : slot;

  always_comb begin
    case (st)
      RT:      idx = AW'(va[RX_SH +: RX_W]);
      ST:      idx = AW'(va[SX_SH +: SX_W]);
      default: idx = AW'(va[PG_SHIFT +: PX_W]);
    endcase
  end

  always_comb begin
    fin = 1'b0; flt = 1'b0; code = 2'd0; rmsi = 1'b0;
    raddr = '0; rperm = 2'b00; rmask = '1;
    nbase = base; nst = st;
    case (st)
      IDLE: if (req_valid) begin
        if (!live) fin = 1'b1;
        else if (req_addr == MSI_ADDR) begin
          fin = 1'b1; raddr = req_addr; rperm = 2'b11; rmask = PG_MASK; rmsi = 1'b1;
        end else if (org == '0) begin
          fin = 1'b1; flt = 1'b1; code = 2'd1;
        end else if (req_addr < lo || req_addr > hi) begin
          fin = 1'b1; flt = 1'b1; code = 2'd2;
        end else begin
          nbase = org & ~PG_MASK; nst = RT;
        end
      end
      RT: if (mem_rd_data_valid) begin
        if (etype != RT_TYPE) begin fin = 1'b1; flt = 1'b1; code = 2'd3; end
        else begin nbase = ent & ~ST_ALN; nst = ST; end
      end
      ST: if (mem_rd_data_valid) begin
        if (etype != ST_TYPE) begin fin = 1'b1; flt = 1'b1; code = 2'd3; end
        else begin nbase = ent & ~PT_ALN; nst = PT; end
      end
      default: if (mem_rd_data_valid) begin
        fin = 1'b1;
        if (ent == '0) begin flt = 1'b1; code = 2'd3; end
        else begin
          raddr = ent & ~PG_MASK; rmask = PG_MASK;
          rperm = ent[INV_BIT] ? 2'b00 : 2'b11;
        end
      end
    endcase
    if (fin) nst = IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; va <= '0; base <= '0; slot <= '0;
      rsp_valid <= 1'b0; rsp_addr <= '0; rsp_perm <= 2'b00; rsp_mask <= '0; rsp_msi <= 1'b0;
      err_valid <= 1'b0; err_code <= 2'd0; err_slot <= '0; err_addr <= '0; err_word <= '0;
      slot_err <= '0;
    end else begin
      st <= nst;
      base <= nbase;
      if (st == IDLE && req_valid) begin
        va <= req_addr;
        slot <= req_slot;
      end
      rsp_valid <= fin;
      err_valid <= flt;
      if (fin) begin
        rsp_addr <= raddr; rsp_perm <= rperm; rsp_mask <= rmask; rsp_msi <= rmsi;
      end
      if (flt) begin
        err_code <= code;
        err_slot <= cur_slot;
        err_addr <= cur_addr;
        err_word <= (code == 2'd3) ? (32'd1 << Q_BIT) : 32'd0;
        slot_err[cur_slot] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_xlate_walker_chk.sv
module dma_xlate_walker_chk #(
  parameter int SLOTS    = 4,
  parameter int AW       = 64,
  parameter int PG_SHIFT = 12,
  parameter logic [AW-1:0] MSI_ADDR = 'h0000_0000_FEE0_0000,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_rd_valid,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rd_data_valid,
  input logic             rsp_valid,
  input logic [AW-1:0]    rsp_addr,
  input logic [1:0]       rsp_perm,
  input logic [AW-1:0]    rsp_mask,
  input logic             rsp_msi,
  input logic             err_valid,
  input logic [SW-1:0]    err_slot,
  input logic [SLOTS-1:0] slot_err
);
  localparam logic [AW-1:0] PG_MASK = {{(AW-PG_SHIFT){1'b0}}, {PG_SHIFT{1'b1}}};

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_idle_noread_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_valid);
  p_fault_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> rsp_valid && rsp_perm == 2'b00 && !rsp_msi);
  p_fault_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> slot_err[err_slot]);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((slot_err & $past(slot_err)) == $past(slot_err)));
  p_msi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_msi |-> rsp_perm == 2'b11 && rsp_mask == PG_MASK && rsp_addr == MSI_ADDR);
  p_grant_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm != 2'b00 |-> rsp_mask == PG_MASK);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_data_valid |=> mem_rd_valid && $stable(mem_rd_addr));
endmodule

bind dma_xlate_walker dma_xlate_walker_chk #(
  .SLOTS(SLOTS), .AW(AW), .PG_SHIFT(PG_SHIFT), .MSI_ADDR(MSI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_valid(mem_rd_valid),
  .mem_rd_addr(mem_rd_addr), .mem_rd_data_valid(mem_rd_data_valid),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_perm(rsp_perm),
  .rsp_mask(rsp_mask), .rsp_msi(rsp_msi), .err_valid(err_valid),
  .err_slot(err_slot), .slot_err(slot_err)
);

// File: tb/tb_dma_xlate_walker.sv
module tb_dma_xlate_walker;
  localparam int SLOTS = 4;
  localparam int AW = 64;
  localparam logic [63:0] MSI = 64'h0000_0000_FEE0_0000;
  localparam logic [63:0] RT_BASE  = 64'h1_0000;
  localparam logic [63:0] SEG_BASE = 64'h100_0000;
  localparam logic [63:0] PT_BASE  = 64'h8000_0000;
  localparam logic [63:0] ORIGIN   = RT_BASE | 64'h5A;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [63:0] req_addr = 0;
  logic [1:0] req_slot = 0;
  logic busy;
  logic [3:0] slot_cfg = 4'hF, slot_used = 4'hF;
  logic [SLOTS*AW-1:0] slot_org, slot_lo, slot_hi;
  logic mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic mem_rd_data_valid = 0;
  logic [63:0] mem_rd_data = 0;
  logic rsp_valid, rsp_msi, err_valid;
  logic [63:0] rsp_addr, rsp_mask, err_addr;
  logic [1:0] rsp_perm, err_code, err_slot;
  logic [31:0] err_word;
  logic [3:0] slot_err;

  dma_xlate_walker #(.SLOTS(SLOTS), .AW(AW), .MSI_ADDR(MSI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_slot(req_slot),
    .busy(busy), .slot_cfg(slot_cfg), .slot_used(slot_used), .slot_org(slot_org),
    .slot_lo(slot_lo), .slot_hi(slot_hi), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_perm(rsp_perm), .rsp_mask(rsp_mask), .rsp_msi(rsp_msi),
    .err_valid(err_valid), .err_code(err_code), .err_slot(err_slot), .err_addr(err_addr),
    .err_word(err_word), .slot_err(slot_err));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int lat = 0, wcnt = 0, rd_n = 0, rsp_cnt = 0;
  logic [63:0] rd_log [4];

  function automatic logic [63:0] memf(logic [63:0] a);
    logic [63:0] off;
    if (a >= RT_BASE && a < RT_BASE + 64'h4000) begin
      off = (a - RT_BASE) >> 3;
      return (SEG_BASE + off * 64'h4000) | ((off % 4 == 3) ? 64'h8 : 64'hC) | 64'h1;
    end else if (a >= SEG_BASE && a < SEG_BASE + 64'h2000_0000) begin
      off = (a - SEG_BASE) >> 3;
      return (PT_BASE + off * 64'h800) | (((off & 64'h7FF) % 5 == 4) ? 64'hC : 64'h8) | 64'h1;
    end else if (a >= PT_BASE) begin
      off = (a - PT_BASE) >> 3;
      if ((off & 64'hFF) % 7 == 6) return 64'h0;
      return ((64'h10_0000 + off) << 12) | (((off & 64'hFF) % 3 == 2) ? 64'h400 : 64'h0) | 64'h1;
    end
    return 64'h0;
  endfunction

  always @(negedge clk) begin
    if (rsp_valid) rsp_cnt++;
    if (mem_rd_valid) begin
      if (wcnt >= lat) begin
        mem_rd_data_valid = 1'b1;
        mem_rd_data = memf(mem_rd_addr);
        if (rd_n < 4) rd_log[rd_n] = mem_rd_addr;
        rd_n++;
        wcnt = 0;
      end else begin
        mem_rd_data_valid = 1'b0;
        wcnt++;
      end
    end else begin
      mem_rd_data_valid = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  logic got;
  int cyc;
  logic [63:0] c_addr, c_mask, c_eaddr;
  logic [1:0] c_perm, c_code, c_eslot;
  logic c_msi, c_err;
  logic [31:0] c_word;

  task automatic run(input logic [63:0] a, input logic [1:0] s);
    @(negedge clk);
    req_addr = a; req_slot = s; req_valid = 1; rd_n = 0; cyc = 0; got = 0;
    while (!got && cyc < 200) begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (rsp_valid) begin
        got = 1;
        c_addr = rsp_addr; c_mask = rsp_mask; c_perm = rsp_perm; c_msi = rsp_msi;
        c_err = err_valid; c_code = err_code; c_eslot = err_slot; c_eaddr = err_addr; c_word = err_word;
      end
    end
    chk(got, "R10 response arrives", 64'(got), 64'd1);
  endtask

  task automatic set_slot(input int s, input logic [63:0] org, input logic [63:0] lo, input logic [63:0] hi);
    slot_org[s*AW +: AW] = org;
    slot_lo[s*AW +: AW] = lo;
    slot_hi[s*AW +: AW] = hi;
  endtask

  task automatic walk(input logic [63:0] a, input logic [1:0] s);
    logic [63:0] rx, sx, px, off, exp_pte;
    int nreads;
    rx = (a >> 31) & 64'h7FF; sx = (a >> 20) & 64'h7FF; px = (a >> 12) & 64'hFF;
    off = ((rx << 11) | sx) << 8 | px;
    nreads = (rx % 4 == 3) ? 1 : (sx % 5 == 4) ? 2 : 3;
    run(a, s);
    chk(rd_n == nreads, "R2 read count", 64'(rd_n), 64'(nreads));
    chk(rd_log[0] == RT_BASE + rx * 8, "R1 region read address", rd_log[0], RT_BASE + rx * 8);
    if (nreads > 1)
      chk(rd_log[1] == SEG_BASE + rx * 64'h4000 + sx * 8, "R1 segment read address",
          rd_log[1], SEG_BASE + rx * 64'h4000 + sx * 8);
    if (nreads > 2)
      chk(rd_log[2] == PT_BASE + ((rx << 11) | sx) * 64'h800 + px * 8, "R1 page read address",
          rd_log[2], PT_BASE + ((rx << 11) | sx) * 64'h800 + px * 8);
    if (nreads < 3 || px % 7 == 6) begin
      chk(c_err && c_code == 2'd3 && c_word == 32'd1, "R7 walk fault code/qualifier",
          {c_err, 30'd0, c_code, c_word}, {1'b1, 30'd0, 2'd3, 32'd1});
      chk(c_perm == 2'b00 && c_addr == 0 && c_mask == '1 && c_eaddr == a && c_eslot == s,
          "R9 fault response fields", c_eaddr, a);
    end else begin
      exp_pte = (64'h10_0000 + off) << 12;
      chk(!c_err, "R8 no fault on good walk", 64'(c_err), 64'd0);
      chk(c_addr == exp_pte && c_mask == 64'hFFF && !c_msi, "R8 page address", c_addr, exp_pte);
      chk(c_perm == ((px % 3 == 2) ? 2'b00 : 2'b11), "R8 permission", 64'(c_perm),
          (px % 3 == 2) ? 64'd0 : 64'd3);
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) set_slot(s, ORIGIN, 64'h0, '1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rsp_valid && !err_valid && !mem_rd_valid && slot_err == 0, "R11 reset state",
        {busy, rsp_valid, err_valid, mem_rd_valid, slot_err}, 64'd0);

    // R3: unconfigured slot and empty slot
    slot_cfg = 4'b1101;
    run(64'h1234_5000, 2'd1);
    chk(cyc == 1 && rd_n == 0 && !c_err && c_perm == 0 && c_addr == 0 && c_mask == '1,
        "R3 unconfigured slot", 64'(cyc), 64'd1);
    slot_cfg = 4'hF; slot_used = 4'b1101;
    run(64'h1234_5000, 2'd1);
    chk(cyc == 1 && rd_n == 0 && !c_err && c_perm == 0, "R3 empty slot", 64'(c_perm), 64'd0);
    slot_used = 4'hF;

    // R4: interrupt address bypasses even with zero origin
    set_slot(0, 64'h0, 64'h0, '1);
    run(MSI, 2'd0);
    chk(c_msi && c_addr == MSI && c_perm == 2'b11 && c_mask == 64'hFFF && !c_err && rd_n == 0,
        "R4 interrupt bypass", c_addr, MSI);

    // R5: zero origin
    run(64'h2_3456_7000, 2'd0);
    chk(c_err && c_code == 2'd1 && c_word == 0 && rd_n == 0, "R5 missing origin code", 64'(c_code), 64'd1);
    chk(c_perm == 0 && c_mask == '1 && c_eslot == 0 && c_eaddr == 64'h2_3456_7000, "R9 fault fields",
        c_eaddr, 64'h2_3456_7000);
    chk(slot_err == 4'b0001, "R9 slot error set", 64'(slot_err), 64'd1);
    set_slot(0, ORIGIN, 64'h0, '1);

    // R6: window bounds
    set_slot(2, ORIGIN, 64'h1_0000_0000, 64'h2_0000_0000);
    run(64'h0_FFFF_FFFF, 2'd2);
    chk(c_err && c_code == 2'd2 && c_word == 0 && rd_n == 0, "R6 below lower bound", 64'(c_code), 64'd2);
    run(64'h2_0000_0001, 2'd2);
    chk(c_err && c_code == 2'd2 && c_eslot == 2, "R6 above upper bound", 64'(c_code), 64'd2);
    chk(slot_err == 4'b0101, "R9 slot error sticky", 64'(slot_err), 64'h5);
    walk(64'h1_0000_0000, 2'd2);
    chk(rd_n == 3, "R6 lower bound walked", 64'(rd_n), 64'd3);
    walk(64'h2_0000_0000, 2'd2);
    chk(rd_n == 3, "R6 upper bound walked", 64'(rd_n), 64'd3);
    set_slot(2, ORIGIN, 64'h0, '1);

    // R10: request while busy is ignored
    lat = 2;
    begin
      int base_cnt;
      @(negedge clk);
      base_cnt = rsp_cnt;
      req_addr = 64'h0_0030_5000; req_slot = 2'd3; req_valid = 1; rd_n = 0;
      @(negedge clk); req_valid = 0;
      @(negedge clk);
      chk(busy, "R10 busy during walk", 64'(busy), 64'd1);
      req_addr = MSI; req_slot = 2'd1; req_valid = 1;
      @(negedge clk); req_valid = 0;
      got = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rsp_valid && !got) begin
          got = 1;
          chk(!rsp_msi && rsp_addr == ((64'h10_0000 + ((64'h3 << 8) | 5)) << 12), "R10 first request served",
              rsp_addr, (64'h10_0000 + ((64'h3 << 8) | 5)) << 12);
          @(negedge clk);
          chk(!rsp_valid, "R10 single-cycle pulse", 64'(rsp_valid), 64'd0);
        end
      end
      chk(rsp_cnt - base_cnt == 1, "R10 busy request ignored", 64'(rsp_cnt - base_cnt), 64'd1);
    end

    // R1 R2 R7 R8 R12: sweep with rotating read latency
    begin
      int n = 0;
      logic [63:0] rxs [7] = '{0, 1, 2, 3, 4, 5, 2047};
      logic [63:0] sxs [8] = '{0, 1, 2, 3, 4, 5, 6, 2047};
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 11; k++) begin
            logic [63:0] px;
            px = (k == 10) ? 64'd255 : 64'(k);
            lat = n % 3;
            walk((rxs[i] << 31) | (sxs[j] << 20) | (px << 12) | 64'hABC, 2'(n % 4));
            n++;
          end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule